// File: doc/BRIEF.md
# Interrupt Request Sampling Unit

This block gathers four maskable, active-low interrupt request lines and one nonmaskable, active-low request line. At each instruction boundary it decides whether the processor takes an interrupt, and which kind. The sequencer raises a strobe during the final clock of an instruction's closing machine cycle. On that strobe the unit looks at the synchronized maskable levels and at a latch that holds any nonmaskable edge seen so far.

A nonmaskable request is entered directly. The unit pulses an entry signal and presents the fixed service address 0x00000066, and no bus transaction takes place. A maskable request is entered through the bus instead. The winning line number is held, and a one-cycle pulse asks the bus unit to start an acknowledge cycle. This pulse is aligned to the next tick of the I/O clock, which reaches the block as a one-cycle enable. From the moment a maskable request is accepted until the bus unit reports completion, all further strobes are ignored.

Top module: `intr_sample_unit`

## Requirements
- R1: During and straight after synchronous reset, `ack_start`, `nmi_enter`, `ack_line` and `nmi_target` are all zero.
- R2: A falling edge on `nmi_n` sets the pending nonmaskable latch two clocks after the flop that first captures it. Holding `nmi_n` low does not set the latch again once it has been taken.
- R3: Requests are evaluated only in a cycle where `last_clk_stb` is high. A pending nonmaskable latch then gives one `nmi_enter` pulse in the following cycle, and the latch is cleared.
- R4: When `nmi_enter` pulses, `nmi_target` holds 0x00000066 and no `ack_start` results from that sample.
- R5: When the nonmaskable latch and an enabled maskable request are both present at one strobe, only the nonmaskable entry is taken. The maskable request stays visible to later strobes.
- R6: A maskable line counts only when its `irq_n` bit is low, its `line_en` bit is 1 and `mask_en` is 1. The lowest-numbered qualifying line wins, and its index (0 to 3, in binary) appears on `ack_line` together with `ack_start`.
- R7: After a maskable request is accepted, `ack_start` pulses for one cycle. It rises in the cycle after the first `io_tick` seen later than the sampling cycle.
- R8: From the acceptance of a maskable request until an `ack_done` pulse that arrives after `ack_start`, strobes have no effect on either output. An `ack_done` pulse at any other time is ignored.
- R9: Maskable pins pass through two synchronizing flops. A request that goes low in the same cycle as the strobe is not seen at that strobe.
- R10: If a new falling edge on `nmi_n` arrives in the same cycle that the latch is cleared by an entry, the latch stays set, and the next strobe gives a second entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_n | input | 4 | Maskable request pins, active low, asynchronous |
| nmi_n | input | 1 | Nonmaskable request pin, active low, edge sensitive |
| line_en | input | 4 | Per-line enable, 1 = line may interrupt |
| mask_en | input | 1 | Global enable for all maskable lines |
| last_clk_stb | input | 1 | Marks the final clock of an instruction |
| io_tick | input | 1 | One-cycle enable at each rising edge of the I/O clock |
| ack_done | input | 1 | Bus unit reports the acknowledge transaction finished |
| ack_start | output | 1 | One-cycle request to start an acknowledge transaction |
| ack_line | output | 2 | Index of the line being acknowledged |
| nmi_enter | output | 1 | One-cycle pulse: take the nonmaskable entry |
| nmi_target | output | 32 | Entry address for the nonmaskable routine |

## Verification
The assertions take for granted that `ack_done` means completion only while a transaction is outstanding, and that `io_tick` and `last_clk_stb` are single-cycle enables on the core clock. The pins themselves may change at any cycle. The bench drives `io_tick` from a fixed divider and gives strobes and completion pulses single-cycle widths. It drives `ack_done` freely, including when nothing is outstanding, so that the ignore rule is exercised. Edge coincidences are placed by counting exact cycles.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAITIO = 2'd1,
    ST_BUS    = 2'd2
  } ack_state_t;

  localparam int unsigned ADDR_W       = 32;
  localparam logic [ADDR_W-1:0] NMI_ENTRY = 32'h0000_0066;
endpackage

// File: rtl/irqs_sync.sv
module irqs_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= {W{RST_BIT}};
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irqs_nmi_latch.sv
module irqs_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic lvl_n,
  input  logic clr,
  output logic pend
);
  logic prev_n;
  logic fall;

  assign fall = prev_n & ~lvl_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_n <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_n <= lvl_n;
      pend   <= fall | (pend & ~clr);
    end
  end

  a_r2_fall_sets: assert property (@(posedge clk) disable iff (rst)
    fall |=> pend);
  a_r10_fall_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (fall && clr) |=> pend);
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr && !fall) |=> !pend);
endmodule

// File: rtl/irqs_prio.sv
module irqs_prio #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqs_ack_fsm.sv
module irqs_ack_fsm
  import irqs_pkg::*;
#(
  parameter int unsigned IW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              nmi_pend,
  input  logic              mreq_any,
  input  logic [IW-1:0]     mreq_idx,
  input  logic              io_tick,
  input  logic              ack_done,
  output logic              nmi_take,
  output logic              ack_start,
  output logic [IW-1:0]     ack_line,
  output logic              nmi_enter,
  output logic [ADDR_W-1:0] nmi_target
);
  ack_state_t    st;
  logic [IW-1:0] line_q;
  logic          sample;
  logic          take_mask;

  assign sample    = strobe && (st == ST_IDLE);
  assign nmi_take  = sample && nmi_pend;
  assign take_mask = sample && !nmi_pend && mreq_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      line_q     <= '0;
      ack_start  <= 1'b0;
      ack_line   <= '0;
      nmi_enter  <= 1'b0;
      nmi_target <= '0;
    end else begin
      nmi_enter <= nmi_take;
      ack_start <= 1'b0;
      if (nmi_take) nmi_target <= NMI_ENTRY;
      unique case (st)
        ST_IDLE: if (take_mask) begin
          st     <= ST_WAITIO;
          line_q <= mreq_idx;
        end
        ST_WAITIO: if (io_tick) begin
          ack_start <= 1'b1;
          ack_line  <= line_q;
          st        <= ST_BUS;
        end
        ST_BUS: if (ack_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r7_ack_follows_tick: assert property (@(posedge clk) disable iff (rst)
    ack_start |-> $past(io_tick));
  a_r8_bus_held: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BUS && !ack_done) |=> (st == ST_BUS));
  a_r4_entry_address: assert property (@(posedge clk) disable iff (rst)
    nmi_enter |-> (nmi_target == NMI_ENTRY && !ack_start));
  a_r5_nmi_wins: assert property (@(posedge clk) disable iff (rst)
    (sample && nmi_pend) |=> (st == ST_IDLE));
endmodule

// File: rtl/intr_sample_unit.sv
module intr_sample_unit
  import irqs_pkg::*;
#(
  parameter int unsigned N_LINES = 4,
  parameter int unsigned SYNC_N  = 2,
  localparam int unsigned IW     = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_n,
  input  logic               nmi_n,
  input  logic [N_LINES-1:0] line_en,
  input  logic               mask_en,
  input  logic               last_clk_stb,
  input  logic               io_tick,
  input  logic               ack_done,
  output logic               ack_start,
  output logic [IW-1:0]      ack_line,
  output logic               nmi_enter,
  output logic [ADDR_W-1:0]  nmi_target
);
  logic [N_LINES-1:0] irq_s;
  logic               nmi_s_n;
  logic               nmi_pend;
  logic               nmi_take;
  logic               mreq_any;
  logic [IW-1:0]      mreq_idx;
  logic [N_LINES-1:0] qual;

  irqs_sync #(.W(N_LINES), .STAGES(SYNC_N), .RST_BIT(1'b0)) u_msync (
    .clk(clk), .rst(rst), .d(~irq_n), .q(irq_s));

  irqs_sync #(.W(1), .STAGES(SYNC_N), .RST_BIT(1'b1)) u_nsync (
    .clk(clk), .rst(rst), .d(nmi_n), .q(nmi_s_n));

  irqs_nmi_latch u_nlat (
    .clk(clk), .rst(rst), .lvl_n(nmi_s_n), .clr(nmi_take), .pend(nmi_pend));

  assign qual = mask_en ? (irq_s & line_en) : '0;

  irqs_prio #(.N(N_LINES), .IW(IW)) u_prio (
    .req(qual), .any(mreq_any), .idx(mreq_idx));

  irqs_ack_fsm #(.IW(IW)) u_fsm (
    .clk(clk), .rst(rst), .strobe(last_clk_stb), .nmi_pend(nmi_pend),
    .mreq_any(mreq_any), .mreq_idx(mreq_idx), .io_tick(io_tick),
    .ack_done(ack_done), .nmi_take(nmi_take), .ack_start(ack_start),
    .ack_line(ack_line), .nmi_enter(nmi_enter), .nmi_target(nmi_target));

  a_r6_winner_qualified: assert property (@(posedge clk) disable iff (rst)
    (last_clk_stb && mreq_any) |-> (qual[mreq_idx] && mask_en));
  a_r3_single_entry_kind: assert property (@(posedge clk) disable iff (rst)
    !(nmi_enter && ack_start));
endmodule

// File: tb/sim_intr_sample_unit.sv
module sim_intr_sample_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] irq_n = 4'hF;
  logic nmi_n = 1'b1;
  logic [3:0] line_en = 4'hF;
  logic mask_en = 1'b1;
  logic last_clk_stb = 1'b0;
  logic io_tick = 1'b0;
  logic ack_done = 1'b0;
  logic ack_start, nmi_enter;
  logic [1:0] ack_line;
  logic [31:0] nmi_target;

  always #2.5 clk = ~clk;

  intr_sample_unit u0 (.clk(clk), .rst(rst), .irq_n(irq_n), .nmi_n(nmi_n),
    .line_en(line_en), .mask_en(mask_en), .last_clk_stb(last_clk_stb),
    .io_tick(io_tick), .ack_done(ack_done), .ack_start(ack_start),
    .ack_line(ack_line), .nmi_enter(nmi_enter), .nmi_target(nmi_target));

  int checks = 0, fails = 0, cyc = 0, cnt_nmi = 0, cnt_ack = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: pipelines as small queues, state as integers
  bit mi_q[$][4];
  logic [3:0] m_s1, m_s2;
  bit n_hist[$];
  bit m_lat;
  int m_st, m_sel;
  bit m_ack, m_nmi;
  logic [1:0] m_line;
  logic [31:0] m_tgt;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; n_hist = '{1, 1, 1}; m_lat = 0; m_st = 0; m_sel = 0;
      m_ack = 0; m_nmi = 0; m_line = 0; m_tgt = 0;
    end else begin
      bit fall, smp, tn, tm;
      int win;
      fall = n_hist[2] && !n_hist[1];
      smp = last_clk_stb && m_st == 0;
      tn = smp && m_lat;
      win = -1;
      for (int i = 3; i >= 0; i--) if (m_s2[i] && line_en[i] && mask_en) win = i;
      tm = smp && !m_lat && win >= 0;
      m_ack = 0;
      if (m_st == 1 && io_tick) begin m_ack = 1; m_line = m_sel[1:0]; m_st = 2; end
      else if (m_st == 2 && ack_done) m_st = 0;
      else if (m_st == 0 && tm) begin m_st = 1; m_sel = win; end
      m_nmi = tn;
      if (tn) m_tgt = 32'h66;
      m_lat = fall || (m_lat && !tn);
      n_hist.pop_back();
      n_hist.push_front(nmi_n);
      m_s2 = m_s1; m_s1 = ~irq_n;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(ack_start == m_ack, "R7 ack_start", ack_start, m_ack);
      chk(!m_ack || ack_line == m_line, "R6 ack_line", ack_line, m_line);
      chk(nmi_enter == m_nmi, "R3 nmi_enter", nmi_enter, m_nmi);
      chk(nmi_target == m_tgt, "R4 nmi_target", nmi_target, m_tgt);
      cnt_nmi += nmi_enter;
      cnt_ack += ack_start;
    end
    cyc++;
    io_tick <= (cyc % 4 == 3);
    if (cyc > 150000 && !done_flag) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic finish_run();
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stb();
    @(negedge clk) last_clk_stb = 1;
    @(negedge clk) last_clk_stb = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk) ack_done = 1;
    @(negedge clk) ack_done = 0;
  endtask

  initial begin
    int bn, ba;
    wt(3);
    chk(!ack_start && !nmi_enter && ack_line == 0 && nmi_target == 0, "R1 reset", nmi_target, 0);
    rst = 0;
    wt(2);
    chk(!ack_start && !nmi_enter && nmi_target == 0, "R1 after reset", nmi_target, 0);

    // R2/R3: held-low NMI gives one entry only
    bn = cnt_nmi; nmi_n = 0; wt(5); stb(); wt(3); stb(); wt(3);
    chk(cnt_nmi - bn == 1, "R2 single edge", cnt_nmi - bn, 1);
    nmi_n = 1; wt(4);

    // R5: NMI beats maskable line 0, maskable served next
    bn = cnt_nmi; ba = cnt_ack; irq_n = 4'b1110; nmi_n = 0; wt(5); stb(); wt(3);
    chk(cnt_nmi - bn == 1 && cnt_ack == ba, "R5 nmi first", cnt_ack - ba, 0);
    stb(); wt(8);
    chk(cnt_ack - ba == 1, "R7 ack issued", cnt_ack - ba, 1);
    chk(ack_line == 0, "R6 line0", ack_line, 0);
    done_pulse(); irq_n = 4'hF; nmi_n = 1; wt(4);

    // R6: lowest enabled active line, global mask
    irq_n = 4'b0101; line_en = 4'b1010; ba = cnt_ack; wt(4); stb(); wt(8);
    chk(cnt_ack - ba == 1 && ack_line == 1, "R6 lowest enabled", ack_line, 1);
    done_pulse(); mask_en = 0; ba = cnt_ack; stb(); wt(8);
    chk(cnt_ack == ba, "R6 global mask off", cnt_ack - ba, 0);
    mask_en = 1; line_en = 4'b1000; stb(); wt(8);
    chk(cnt_ack - ba == 1 && ack_line == 3, "R6 line3", ack_line, 3);

    // R8: strobes ignored while outstanding
    bn = cnt_nmi; nmi_n = 0; wt(5); stb(); stb(); wt(3);
    chk(cnt_nmi == bn, "R8 ignored while busy", cnt_nmi - bn, 0);
    irq_n = 4'hF; done_pulse(); stb(); wt(3);
    chk(cnt_nmi - bn == 1, "R8 resumes after done", cnt_nmi - bn, 1);
    nmi_n = 1; line_en = 4'hF; done_pulse(); wt(4);

    // R9: request arriving with the strobe is not seen
    ba = cnt_ack;
    @(negedge clk) begin irq_n = 4'b1011; last_clk_stb = 1; end
    @(negedge clk) last_clk_stb = 0;
    wt(8);
    chk(cnt_ack == ba, "R9 sync delay", cnt_ack - ba, 0);
    stb(); wt(8);
    chk(cnt_ack - ba == 1 && ack_line == 2, "R9 seen later", ack_line, 2);
    irq_n = 4'hF; done_pulse(); wt(4);

    // R10: new edge in the clearing cycle
    nmi_n = 0; wt(4); nmi_n = 1; wt(4);
    bn = cnt_nmi;
    @(negedge clk) nmi_n = 0;
    wt(2);
    last_clk_stb = 1;
    @(negedge clk) last_clk_stb = 0;
    wt(3);
    chk(cnt_nmi - bn == 1, "R10 first entry", cnt_nmi - bn, 1);
    stb(); wt(3);
    chk(cnt_nmi - bn == 2, "R10 second entry", cnt_nmi - bn, 2);
    nmi_n = 1; wt(4);

    // mixed random traffic against the reference
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) irq_n = 4'($urandom);
      if ($urandom_range(0, 9) == 0) nmi_n = ~nmi_n;
      if ($urandom_range(0, 15) == 0) line_en = 4'($urandom);
      if ($urandom_range(0, 15) == 0) mask_en = ~mask_en;
      last_clk_stb = ($urandom_range(0, 3) == 0);
      ack_done = ($urandom_range(0, 5) == 0);
    end
    @(negedge clk) begin last_clk_stb = 0; ack_done = 0; end
    wt(4);
    finish_run();
  end
endmodule